// File: doc/BRIEF.md
# Bank-Switched Upper Memory Controller

This controller sits beside a CPU bus. It watches every bus cycle for accesses that land in a sixteen-address control window. From those accesses it keeps three pieces of state: where upper-region reads come from (ROM or RAM), which of two 4K banks backs the D000–DFFF range, and whether RAM may be written. CPU accesses to the 12K upper region (D000–FFFF) are then steered. Reads go either to ROM or to a 16K RAM. Writes reach that RAM only when writing has been armed.

Each bus cycle is given as an address, a read/write flag and a one-cycle strobe. The state changes on the clock edge that ends a strobed window access, and the new state applies to the next cycle. The read-source select, bank bit and translated RAM address are available to the surrounding memory logic at all times. The RAM write strobe is combinational with the bus cycle it qualifies. All pins are plain control or address signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `upper_bank_ctrl`

## Requirements
- R1: After reset the block selects ROM as the read source (`rom_sel`=1) and selects bank 2 (`bank_sel`=0), and RAM writes are disabled.
- R2: A strobed access to window offset `o` (address C080+`o`) sets `bank_sel` to `o[3]`: 1 means bank 1 and 0 means bank 2. Offset bit 2 is ignored, so `o` and `o`^4 act identically.
- R3: The read source follows `o[1:0]` from the first access. Codes 00 and 11 select RAM (`rom_sel`=0). Codes 01 and 10 select ROM (`rom_sel`=1).
- R4: Any strobed access, read or write, to an even offset disables RAM writes and clears the arming count.
- R5: RAM writes become enabled after two strobed read cycles to odd offsets with no intervening window access that breaks the run. The two offsets may differ, and they may be two identical back-to-back reads. A single odd read does not enable writes.
- R6: A strobed write cycle to an odd offset clears the arming count but leaves writes enabled if they already were. It still updates the bank and the read source.
- R7: Strobed accesses outside the window, and unstrobed cycles, change no state, and they do not break a run of odd reads.
- R8: RAM address map: bank 2 D000–DFFF maps to 0000–0FFF, bank 1 D000–DFFF maps to 1000–1FFF, and E000–FFFF maps to 2000–3FFF regardless of the bank.
- R9: `ram_we` is 1 only during a strobed CPU write to D000–FFFF while writes are enabled. It is 0 for reads and for writes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address of the current cycle |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_stb | input | 1 | One-cycle strobe marking a valid bus cycle |
| rom_sel | output | 1 | 1 = upper-region reads come from ROM, 0 = from RAM |
| ram_we | output | 1 | RAM write strobe for the current cycle |
| bank_sel | output | 1 | 1 = bank 1, 0 = bank 2 for D000–DFFF |
| ram_addr | output | 14 | Translated RAM address for the current bus address |

## Verification
A wrong read source or bank shows on `rom_sel` or `bank_sel` in the cycle after the offending window access. A wrong write-enable or arming count stays hidden until the next CPU write to the upper region, where `ram_we` exposes it in that same cycle. The bench therefore follows every state-changing sequence with such a probe write. An arming count that is wrong but not yet effective only shows one further odd read later. Sweeping every pair of window accesses catches that case, because the second access either enables writes or does not.

// File: rtl/ubc_pkg.sv
package ubc_pkg;
  localparam int ADDR_W = 16;
  localparam int RAM_AW = 14;

  typedef struct packed {
    logic rd_ram;
    logic bank1;
    logic wen;
  } ubc_state_t;

  typedef struct packed {
    logic upd;      // strobed access inside the window
    logic rd_ram;   // read source the access selects
    logic bank1;    // bank the access selects
    logic kill;     // even offset: disable writes, clear count
    logic arm_rd;   // odd offset, read cycle
    logic arm_clr;  // odd offset, write cycle
  } ubc_cmd_t;
endpackage

// File: rtl/ubc_sw_decode.sv
module ubc_sw_decode
  import ubc_pkg::*;
(
  input  logic       hit,
  input  logic       wr,
  input  logic       off_bank,
  input  logic [1:0] off_lo,
  output ubc_cmd_t   cmd
);
  always_comb begin
    cmd.upd     = hit;
    cmd.bank1   = off_bank;
    cmd.rd_ram  = (off_lo == 2'b00) || (off_lo == 2'b11);
    cmd.kill    = hit && !off_lo[0];
    cmd.arm_rd  = hit && off_lo[0] && !wr;
    cmd.arm_clr = hit && off_lo[0] && wr;
  end
endmodule

// File: rtl/ubc_sw_state.sv
module ubc_sw_state
  import ubc_pkg::*;
#(
  parameter int ARM_COUNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ubc_cmd_t   cmd,
  output ubc_state_t st_q
);
  localparam int CNT_W = $clog2(ARM_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ARM_COUNT);

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q.rd_ram <= 1'b0;
      st_q.bank1  <= 1'b0;
      st_q.wen    <= 1'b0;
      cnt_q       <= '0;
    end else if (cmd.upd) begin
      st_q.rd_ram <= cmd.rd_ram;
      st_q.bank1  <= cmd.bank1;
      if (cmd.kill) begin
        st_q.wen <= 1'b0;
        cnt_q    <= '0;
      end else if (cmd.arm_clr) begin
        cnt_q <= '0;
      end else if (cmd.arm_rd) begin
        cnt_q <= cnt_inc;
        if (cnt_inc == CNT_MAX) st_q.wen <= 1'b1;
      end
    end
  end

  // R4
  even_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.upd && cmd.kill |=> !st_q.wen);

  // R5
  wen_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.wen) |-> $past(cmd.upd && cmd.arm_rd));

  // R6
  odd_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.upd && cmd.arm_clr && st_q.wen |=> st_q.wen);
endmodule

// File: rtl/ubc_addr_map.sv
module ubc_addr_map
  import ubc_pkg::*;
#(
  parameter logic [3:0] BANK_NIB = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank1,
  output logic              upper_hit,
  output logic [RAM_AW-1:0] ram_addr
);
  logic in_bank, in_common;

  assign in_bank   = addr[15:12] == BANK_NIB;
  assign in_common = addr[15:13] == 3'b111;
  assign upper_hit = in_bank || in_common;

  always_comb begin
    if (in_common) ram_addr = {1'b1, addr[12:0]};
    else           ram_addr = {1'b0, bank1, addr[11:0]};
  end

  // R8
  common_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_common |-> ram_addr[13] && ram_addr[12] == addr[12]);

  // R8
  bank_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_bank |-> !ram_addr[13] && ram_addr[12] == bank1);
endmodule

// File: rtl/upper_bank_ctrl.sv
module upper_bank_ctrl
  import ubc_pkg::*;
#(
  parameter logic [15:0] WIN_BASE  = 16'hC080,
  parameter int          ARM_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic              bus_stb,
  output logic              rom_sel,
  output logic              ram_we,
  output logic              bank_sel,
  output logic [13:0]       ram_addr
);
  logic       win_hit, upper_hit;
  ubc_cmd_t   cmd;
  ubc_state_t st;

  assign win_hit = bus_stb && (bus_addr[15:4] == WIN_BASE[15:4]);

  ubc_sw_decode u_dec (
    .hit      (win_hit),
    .wr       (bus_wr),
    .off_bank (bus_addr[3]),
    .off_lo   (bus_addr[1:0]),
    .cmd      (cmd)
  );

  ubc_sw_state #(.ARM_COUNT(ARM_COUNT)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .st_q  (st)
  );

  ubc_addr_map u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .bank1     (st.bank1),
    .upper_hit (upper_hit),
    .ram_addr  (ram_addr)
  );

  assign rom_sel  = !st.rd_ram;
  assign bank_sel = st.bank1;
  assign ram_we   = bus_stb && bus_wr && upper_hit && st.wen;

  // R7
  outside_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |=> $stable(st));

  // R9
  we_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> bus_wr && bus_stb);
endmodule

// File: tb/upper_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module upper_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic        bus_stb = 1'b0;
  logic        rom_sel, ram_we, bank_sel;
  logic [13:0] ram_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // model state
  logic m_rom, m_bank1, m_wen;
  int   m_cnt;

  always #2.5 clk = ~clk;

  upper_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_stb(bus_stb), .rom_sel(rom_sel), .ram_we(ram_we),
    .bank_sel(bank_sel), .ram_addr(ram_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_acc(input logic [15:0] a, input logic wr);
    logic [3:0] o;
    if (a[15:4] != 12'hC08) return;
    o = a[3:0];
    m_bank1 = o[3];
    m_rom   = (o[1:0] == 2'b01) || (o[1:0] == 2'b10);
    if (!o[0]) begin
      m_wen = 1'b0; m_cnt = 0;
    end else if (wr) begin
      m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
      if (m_cnt >= 2) m_wen = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_rom = 1'b1; m_bank1 = 1'b0; m_wen = 1'b0; m_cnt = 0;
  endtask

  task automatic acc(input logic [15:0] a, input logic wr);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_stb = 1'b1;
    @(negedge clk);
    bus_stb = 1'b0; bus_wr = 1'b0;
    model_acc(a, wr);
  endtask

  // returns ram_we seen during a strobed write to the given address
  task automatic probe_we(input logic [15:0] a, input logic wr, output logic we);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_stb = 1'b1;
    #1 we = ram_we;
    @(negedge clk);
    bus_stb = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic check_state(input string tag);
    logic we;
    chk({tag, " R3 rom_sel"}, rom_sel, m_rom);
    chk({tag, " R2 bank_sel"}, bank_sel, m_bank1);
    probe_we(16'hFE1F, 1'b1, we);
    chk({tag, " R4 R5 R6 write enable"}, we, m_wen);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic we;
    do_reset();
    // R1 reset state
    chk("R1 rom_sel after reset", rom_sel, 1);
    chk("R1 bank_sel after reset", bank_sel, 0);
    probe_we(16'hD000, 1'b1, we);
    chk("R1 writes disabled after reset", we, 0);

    // exhaustive pairs of window accesses
    for (int a = 0; a < 16; a++)
      for (int wa = 0; wa < 2; wa++)
        for (int b = 0; b < 16; b++)
          for (int wb = 0; wb < 2; wb++) begin
            do_reset();
            acc(16'hC080 + 16'(a), wa[0]);
            acc(16'hC080 + 16'(b), wb[0]);
            check_state("pair");
          end

    // R6: enabled survives two later writes to offset 1
    do_reset();
    acc(16'hC081, 1'b0); acc(16'hC081, 1'b0);
    acc(16'hC081, 1'b1); acc(16'hC081, 1'b1);
    check_state("R6 two stores");
    // R6: read, write, read to offset B leaves writes off
    do_reset();
    acc(16'hC08B, 1'b0); acc(16'hC08B, 1'b1); acc(16'hC08B, 1'b0);
    check_state("R6 read-write-read");
    chk("R6 read-write-read wen off", m_wen, 0);

    // R7: outside accesses change nothing and keep the run
    do_reset();
    acc(16'hC08B, 1'b0);
    acc(16'h0400, 1'b0); acc(16'hD000, 1'b0);
    acc(16'hC090, 1'b0); acc(16'hC07B, 1'b1);
    acc(16'hC08B, 1'b0);
    check_state("R7 run kept");
    chk("R7 run kept wen", m_wen, 1);
    do_reset();
    acc(16'hC093, 1'b0); acc(16'hC073, 1'b0);
    check_state("R7 near-window ignored");

    // R9: no strobe outside upper region or on reads
    do_reset();
    acc(16'hC083, 1'b0); acc(16'hC083, 1'b0);
    probe_we(16'hC000, 1'b1, we); chk("R9 write C000", we, 0);
    probe_we(16'h2000, 1'b1, we); chk("R9 write 2000", we, 0);
    probe_we(16'hCFFF, 1'b1, we); chk("R9 write CFFF", we, 0);
    probe_we(16'hD000, 1'b0, we); chk("R9 read D000", we, 0);
    probe_we(16'hD000, 1'b1, we); chk("R9 write D000", we, 1);
    probe_we(16'hFFFF, 1'b1, we); chk("R9 write FFFF", we, 1);

    // R8: full address map sweep for both banks
    for (int bk = 0; bk < 2; bk++) begin
      do_reset();
      acc(bk ? 16'hC088 : 16'hC080, 1'b0);
      chk("R8 bank setup", bank_sel, bk);
      for (int ad = 16'hD000; ad <= 16'hFFFF; ad++) begin
        int exp;
        bus_addr = 16'(ad);
        #0.01;
        if (ad < 16'hE000) exp = (bk ? 16'h1000 : 0) + (ad - 16'hD000);
        else               exp = 16'h2000 + (ad - 16'hE000);
        chk("R8 ram_addr", ram_addr, exp);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule